// File: doc/BRIEF.md
# Character-Clock Raster Timing Generator

This block produces the horizontal and vertical sync, blanking and display-enable strobes for a raster display. It runs on a character clock, so one clock tick equals eight pixels. The timing comes from a bank of 8-bit registers that a host reaches through a single index/data port. Horizontal values count characters and vertical values count scan lines. The registers hold biased and split encodings rather than plain limits. A total is stored minus a fixed bias. The ninth and tenth bits of the vertical values sit in a shared overflow byte. The sync and blank end values are compared on their low bits only.

Writes go into a pending bank that the host can always read back. The counters run from a working copy, and that copy is refreshed only on the clock edge that wraps the frame, so a frame in progress never mixes old and new settings. One bit of the vertical-sync-end register locks the lower eight registers against writes, except for one overflow bit. A polarity register selects active-low or active-high sync for each direction.

Top module: `crtc_timing_gen`

## Requirements
- R1: The character counter steps 0..N+4, where N is register 0x00, then wraps to 0. Horizontal display holds while the counter is at or below register 0x01.
- R2: Horizontal blank turns on when the next character value equals register 0x02. It turns off when the low 6 bits of the next value equal {reg 0x05 bit 7, reg 0x03 bits 4..0}. If both match on the same character, turn-on wins.
- R3: Horizontal sync turns on when the next character value equals register 0x04. It turns off when the low 5 bits of that value equal register 0x05 bits 4..0. If both match, turn-on wins.
- R4: The line counter advances once per character wrap and steps 0..V+1, where V = {reg 0x07 bit 5, reg 0x07 bit 0, reg 0x06}. Vertical display holds while the line counter is at or below {reg 0x07 bit 6, reg 0x07 bit 1, reg 0x12}.
- R5: Vertical sync turns on at the line {reg 0x07 bit 7, reg 0x07 bit 2, reg 0x10}. It turns off at the first line whose low 4 bits equal register 0x11 bits 3..0.
- R6: Vertical blank turns on at the line {reg 0x09 bit 5, reg 0x07 bit 3, reg 0x15}. It turns off at the first line whose low 8 bits equal register 0x16.
- R7: Display enable is high only when both the horizontal and the vertical display conditions hold.
- R8: While register 0x11 bit 7 is set, writes to registers 0x00..0x06 change nothing. A write to register 0x07 changes only bit 4.
- R9: Register 0x18 bit 6 set makes horizontal sync active low. Bit 7 set makes vertical sync active low. A clear bit gives active-high sync.
- R10: A read returns the last accepted write at once. The generator uses new values only from the clock edge that wraps both counters. A write on that same edge waits for the following frame.
- R11: Reset clears every register, both counters and all flags, so both sync outputs sit at their inactive (low) level.
- R12: Indices 0x19 and above read as zero, and writes to them are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_idx | input | IDX_W | Register index for both write and read |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Pending-bank content at cfg_idx |
| hsync_o | output | 1 | Horizontal sync, polarity applied |
| vsync_o | output | 1 | Vertical sync, polarity applied |
| hblank_o | output | 1 | Horizontal blank, active high |
| vblank_o | output | 1 | Vertical blank, active high |
| de_o | output | 1 | Display enable |

## Verification
Two things can happen in the same cycle: a host write and the end-of-frame load of the working copy. The bench provokes this on purpose. It follows its own arithmetic model to the last character of the last line, then issues a write on exactly the edge that wraps the frame. It then checks that the new value reads back at once but does not steer the frame that starts on that edge, only the one after. The same cycle-by-cycle sweep also covers the other collision. A truncated end match can fall on the line or character after the wrap, and the bench judges it against the model's set-over-clear rule.

// File: rtl/crtc_pkg.sv
package crtc_pkg;

   localparam int CRTC_NREGS = 25;
   localparam int CRTC_DW    = 8;

   // register positions the counters decode
   localparam int IX_HTOT   = 'h00;
   localparam int IX_HDEND  = 'h01;
   localparam int IX_HBSTA  = 'h02;
   localparam int IX_HBEND  = 'h03;
   localparam int IX_HSSTA  = 'h04;
   localparam int IX_HSEND  = 'h05;
   localparam int IX_VTOT   = 'h06;
   localparam int IX_OVFL   = 'h07;
   localparam int IX_SCAN   = 'h09;
   localparam int IX_VSSTA  = 'h10;
   localparam int IX_VSEND  = 'h11;
   localparam int IX_VDEND  = 'h12;
   localparam int IX_VBSTA  = 'h15;
   localparam int IX_VBEND  = 'h16;
   localparam int IX_POLAR  = 'h18;

   localparam int LAST_LOCKED = 'h07;

   typedef logic [CRTC_NREGS-1:0][CRTC_DW-1:0] crtc_bank_t;

   typedef struct packed {
      logic [7:0] h_tot;
      logic [7:0] h_dend;
      logic [7:0] h_bsta;
      logic [5:0] h_bend;
      logic [7:0] h_ssta;
      logic [4:0] h_send;
      logic [9:0] v_tot;
      logic [9:0] v_dend;
      logic [9:0] v_ssta;
      logic [3:0] v_send;
      logic [9:0] v_bsta;
      logic [7:0] v_bend;
      logic       h_neg;
      logic       v_neg;
   } crtc_timing_t;

   function automatic crtc_timing_t crtc_decode(input crtc_bank_t b);
      crtc_timing_t t;
      t.h_tot  = b[IX_HTOT];
      t.h_dend = b[IX_HDEND];
      t.h_bsta = b[IX_HBSTA];
      t.h_bend = {b[IX_HSEND][7], b[IX_HBEND][4:0]};
      t.h_ssta = b[IX_HSSTA];
      t.h_send = b[IX_HSEND][4:0];
      t.v_tot  = {b[IX_OVFL][5], b[IX_OVFL][0], b[IX_VTOT]};
      t.v_dend = {b[IX_OVFL][6], b[IX_OVFL][1], b[IX_VDEND]};
      t.v_ssta = {b[IX_OVFL][7], b[IX_OVFL][2], b[IX_VSSTA]};
      t.v_send = b[IX_VSEND][3:0];
      t.v_bsta = {b[IX_SCAN][5], b[IX_OVFL][3], b[IX_VBSTA]};
      t.v_bend = b[IX_VBEND];
      t.h_neg  = b[IX_POLAR][6];
      t.v_neg  = b[IX_POLAR][7];
      return t;
   endfunction

endpackage

// File: rtl/crtc_regbank.sv
module crtc_regbank
   import crtc_pkg::*;
#(
   parameter int IDX_W = 5
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [IDX_W-1:0]     idx,
   input  logic [CRTC_DW-1:0]   wr_data,
   input  logic                 load,
   output logic [CRTC_DW-1:0]   rd_data,
   output crtc_bank_t           act_bank
);

   localparam int NREG = CRTC_NREGS;

   if (IDX_W < 5) begin : g_bad_idx
      $error("crtc_regbank: IDX_W must reach index 0x18");
   end

   crtc_bank_t pend;
   logic       locked;

   assign locked = pend[IX_VSEND][7];

   for (genvar i = 0; i < NREG; i++) begin : g_reg
      localparam logic [CRTC_DW-1:0] LOCK_KEEP =
         (i == IX_OVFL) ? 8'h10 : ((i <= LAST_LOCKED) ? 8'h00 : 8'hFF);
      logic [CRTC_DW-1:0] wmask;
      logic               hit;

      assign hit   = wr_en && (idx == IDX_W'(i));
      assign wmask = locked ? LOCK_KEEP : 8'hFF;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            pend[i] <= '0;
         end else if (hit) begin
            pend[i] <= (pend[i] & ~wmask) | (wr_data & wmask);
         end
      end

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            act_bank[i] <= '0;
         end else if (load) begin
            act_bank[i] <= pend[i];
         end
      end

      // working copy moves only on the frame edge
      a_r10_hold_working: assert property (@(posedge clk) disable iff (!rst_n)
         !load |=> $stable(act_bank[i]));

      if (i < LAST_LOCKED) begin : g_lock_chk
         a_r8_locked_low: assert property (@(posedge clk) disable iff (!rst_n)
            (hit && locked) |=> $stable(pend[i]));
      end else if (i == LAST_LOCKED) begin : g_ovf_chk
         a_r8_locked_ovfl: assert property (@(posedge clk) disable iff (!rst_n)
            (hit && locked) |=> $stable(pend[i] & 8'hEF));
      end
   end

   always_comb begin
      rd_data = '0;
      if (idx < IDX_W'(NREG)) begin
         rd_data = pend[idx];
      end
   end

endmodule

// File: rtl/crtc_hgen.sv
module crtc_hgen #(
   parameter int HC_W = 9
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [7:0]      tot_m5,
   input  logic [7:0]      bl_sta,
   input  logic [5:0]      bl_end,
   input  logic [7:0]      sy_sta,
   input  logic [4:0]      sy_end,
   output logic [HC_W-1:0] hc,
   output logic            h_last,
   output logic            hblank_f,
   output logic            hsync_f
);

   localparam int BIAS = 4;

   if (HC_W < 9) begin : g_bad_hc
      $error("crtc_hgen: HC_W too small for total plus bias");
   end

   logic [HC_W-1:0] last_val;
   logic [HC_W-1:0] hn;

   assign last_val = HC_W'(tot_m5) + HC_W'(BIAS);
   assign h_last   = (hc == last_val);
   assign hn       = h_last ? '0 : hc + 1'b1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hc       <= '0;
         hblank_f <= 1'b0;
         hsync_f  <= 1'b0;
      end else begin
         hc <= hn;
         if (hn == HC_W'(bl_sta)) begin
            hblank_f <= 1'b1;
         end else if (hn[5:0] == bl_end) begin
            hblank_f <= 1'b0;
         end
         if (hn == HC_W'(sy_sta)) begin
            hsync_f <= 1'b1;
         end else if (hn[4:0] == sy_end) begin
            hsync_f <= 1'b0;
         end
      end
   end

   a_r1_hwrap: assert property (@(posedge clk) disable iff (!rst_n)
      h_last |=> (hc == '0));
   a_r1_hbound: assert property (@(posedge clk) disable iff (!rst_n)
      hc <= last_val);
   a_r3_sync_on: assert property (@(posedge clk) disable iff (!rst_n)
      (!h_last && (hc + 1'b1 == HC_W'(sy_sta))) |=> hsync_f);

endmodule

// File: rtl/crtc_vgen.sv
module crtc_vgen #(
   parameter int VC_W = 11
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            adv,
   input  logic [9:0]      tot_m2,
   input  logic [9:0]      sy_sta,
   input  logic [3:0]      sy_end,
   input  logic [9:0]      bl_sta,
   input  logic [7:0]      bl_end,
   output logic [VC_W-1:0] vc,
   output logic            v_last,
   output logic            vblank_f,
   output logic            vsync_f
);

   localparam int BIAS = 1;

   if (VC_W < 11) begin : g_bad_vc
      $error("crtc_vgen: VC_W too small for total plus bias");
   end

   logic [VC_W-1:0] last_val;
   logic [VC_W-1:0] vn;

   assign last_val = VC_W'(tot_m2) + VC_W'(BIAS);
   assign v_last   = (vc == last_val);
   assign vn       = v_last ? '0 : vc + 1'b1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vc       <= '0;
         vblank_f <= 1'b0;
         vsync_f  <= 1'b0;
      end else if (adv) begin
         vc <= vn;
         if (vn == VC_W'(sy_sta)) begin
            vsync_f <= 1'b1;
         end else if (vn[3:0] == sy_end) begin
            vsync_f <= 1'b0;
         end
         if (vn == VC_W'(bl_sta)) begin
            vblank_f <= 1'b1;
         end else if (vn[7:0] == bl_end) begin
            vblank_f <= 1'b0;
         end
      end
   end

   a_r4_vwrap: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && v_last) |=> (vc == '0));
   a_r4_vhold: assert property (@(posedge clk) disable iff (!rst_n)
      !adv |=> ($stable(vc) && $stable(vsync_f) && $stable(vblank_f)));
   a_r5_vsync_on: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !v_last && (vc + 1'b1 == VC_W'(sy_sta))) |=> vsync_f);

endmodule

// File: rtl/crtc_timing_gen.sv
module crtc_timing_gen
   import crtc_pkg::*;
#(
   parameter int IDX_W = 5,
   parameter int HC_W  = 9,
   parameter int VC_W  = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [IDX_W-1:0] cfg_idx,
   input  logic [7:0]       cfg_wdata,
   output logic [7:0]       cfg_rdata,
   output logic             hsync_o,
   output logic             vsync_o,
   output logic             hblank_o,
   output logic             vblank_o,
   output logic             de_o
);

   crtc_bank_t      act_bank;
   crtc_timing_t    tm;
   logic [HC_W-1:0] hc;
   logic [VC_W-1:0] vc;
   logic            h_last, v_last, frame_load;
   logic            hb_f, hs_f, vb_f, vs_f;

   assign tm         = crtc_decode(act_bank);
   assign frame_load = h_last && v_last;

   crtc_regbank #(.IDX_W(IDX_W)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (cfg_we),
      .idx      (cfg_idx),
      .wr_data  (cfg_wdata),
      .load     (frame_load),
      .rd_data  (cfg_rdata),
      .act_bank (act_bank)
   );

   crtc_hgen #(.HC_W(HC_W)) u_h (
      .clk      (clk),
      .rst_n    (rst_n),
      .tot_m5   (tm.h_tot),
      .bl_sta   (tm.h_bsta),
      .bl_end   (tm.h_bend),
      .sy_sta   (tm.h_ssta),
      .sy_end   (tm.h_send),
      .hc       (hc),
      .h_last   (h_last),
      .hblank_f (hb_f),
      .hsync_f  (hs_f)
   );

   crtc_vgen #(.VC_W(VC_W)) u_v (
      .clk      (clk),
      .rst_n    (rst_n),
      .adv      (h_last),
      .tot_m2   (tm.v_tot),
      .sy_sta   (tm.v_ssta),
      .sy_end   (tm.v_send),
      .bl_sta   (tm.v_bsta),
      .bl_end   (tm.v_bend),
      .vc       (vc),
      .v_last   (v_last),
      .vblank_f (vb_f),
      .vsync_f  (vs_f)
   );

   assign hsync_o  = hs_f ^ tm.h_neg;
   assign vsync_o  = vs_f ^ tm.v_neg;
   assign hblank_o = hb_f;
   assign vblank_o = vb_f;
   assign de_o     = (hc <= HC_W'(tm.h_dend)) && (vc <= VC_W'(tm.v_dend));

   a_r7_de_needs_vertical: assert property (@(posedge clk) disable iff (!rst_n)
      de_o |-> (vc <= VC_W'(tm.v_dend)));
   a_r9_pol_only_at_frame: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_load |=> ($stable(tm.h_neg) && $stable(tm.v_neg)));
   a_r11_quiet_after_reset: assert property (@(posedge clk)
      !rst_n |=> (!hsync_o && !vsync_o && !hblank_o && !vblank_o));

endmodule

// File: tb/sim_crtc_timing_gen.sv
module sim_crtc_timing_gen;

   localparam int CLK_PERIOD = 10;
   localparam int NREG = 25;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_we = 1'b0;
   logic [4:0] cfg_idx = '0;
   logic [7:0] cfg_wdata = '0;
   logic [7:0] cfg_rdata;
   logic       hsync_o, vsync_o, hblank_o, vblank_o, de_o;

   int checks = 0;
   int errors = 0;
   bit cmp_on = 0;

   crtc_timing_gen u0 (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .hsync_o(hsync_o),
      .vsync_o(vsync_o), .hblank_o(hblank_o), .vblank_o(vblank_o), .de_o(de_o)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // arithmetic reference state
   int m_pend [NREG];
   int m_act  [NREG];
   int m_hc, m_vc;
   bit m_hs, m_hb, m_vs, m_vb;

   function automatic int bitof(int v, int b);
      return (v >> b) & 1;
   endfunction
   function automatic int f_hlast();
      return m_act[0] + 4;
   endfunction
   function automatic int f_vlast();
      return (m_act[6] | (bitof(m_act[7],0) << 8) | (bitof(m_act[7],5) << 9)) + 1;
   endfunction
   function automatic int f_vdend();
      return m_act[18] | (bitof(m_act[7],1) << 8) | (bitof(m_act[7],6) << 9);
   endfunction

   always @(posedge clk) begin
      int hn, vn, hss, hse, hbs, hbe, vss, vse, vbs, vbe;
      bit hwrap, vwrap;
      if (!rst_n) begin
         for (int i = 0; i < NREG; i++) begin m_pend[i] = 0; m_act[i] = 0; end
         m_hc = 0; m_vc = 0; m_hs = 0; m_hb = 0; m_vs = 0; m_vb = 0;
      end else begin
         hss = m_act[4];  hse = m_act[5] & 31;
         hbs = m_act[2];  hbe = (m_act[3] & 31) | (bitof(m_act[5],7) << 5);
         vss = m_act[16] | (bitof(m_act[7],2) << 8) | (bitof(m_act[7],7) << 9);
         vse = m_act[17] & 15;
         vbs = m_act[21] | (bitof(m_act[7],3) << 8) | (bitof(m_act[9],5) << 9);
         vbe = m_act[22];
         hwrap = (m_hc == f_hlast());
         hn = hwrap ? 0 : m_hc + 1;
         if (hn == hss) m_hs = 1; else if ((hn & 31) == hse) m_hs = 0;
         if (hn == hbs) m_hb = 1; else if ((hn & 63) == hbe) m_hb = 0;
         if (hwrap) begin
            vwrap = (m_vc == f_vlast());
            vn = vwrap ? 0 : m_vc + 1;
            if (vn == vss) m_vs = 1; else if ((vn & 15) == vse) m_vs = 0;
            if (vn == vbs) m_vb = 1; else if ((vn & 255) == vbe) m_vb = 0;
            m_vc = vn;
            if (vwrap) for (int i = 0; i < NREG; i++) m_act[i] = m_pend[i];
         end
         m_hc = hn;
         if (cfg_we && cfg_idx < NREG) begin
            if (bitof(m_pend[17],7) && cfg_idx < 7) begin
            end else if (bitof(m_pend[17],7) && cfg_idx == 7) begin
               m_pend[7] = (m_pend[7] & 'hEF) | (cfg_wdata & 'h10);
            end else begin
               m_pend[cfg_idx] = cfg_wdata;
            end
         end
      end
   end

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // continuous output comparison against the model
   always @(negedge clk) begin
      if (cmp_on) begin
         chk("R3/R9 hsync", hsync_o, m_hs ^ bitof(m_act[24],6));
         chk("R5/R9 vsync", vsync_o, m_vs ^ bitof(m_act[24],7));
         chk("R2 hblank", hblank_o, m_hb);
         chk("R6 vblank", vblank_o, m_vb);
         chk("R1/R4/R7 de", de_o, (m_hc <= m_act[1]) && (m_vc <= f_vdend()));
      end
   end

   task automatic wr(int idx, int data);
      @(negedge clk);
      cfg_we = 1'b1; cfg_idx = 5'(idx); cfg_wdata = 8'(data);
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic rd(int idx, int exp, string tag);
      @(negedge clk);
      cfg_idx = 5'(idx);
      #1;
      chk(tag, cfg_rdata, exp);
   endtask

   task automatic wr_at_load(int idx, int data);
      @(negedge clk);
      while (!(m_hc == f_hlast() && m_vc == f_vlast())) @(negedge clk);
      cfg_we = 1'b1; cfg_idx = 5'(idx); cfg_wdata = 8'(data);
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R11: reset holds outputs inactive
      chk("R11 hsync", hsync_o, 0);
      chk("R11 vsync", vsync_o, 0);
      chk("R11 hblank", hblank_o, 0);
      chk("R11 vblank", vblank_o, 0);
      rst_n = 1'b1;
      @(negedge clk);
      cmp_on = 1;
      rd(0, 0, "R11 reg clear");
      rd('h11, 0, "R11 reg clear");

      // small configuration: 12 chars x 10 lines
      wr('h00, 7);  wr('h01, 5);  wr('h02, 6);  wr('h03, 10);
      wr('h04, 8);  wr('h05, 10); wr('h06, 8);  wr('h12, 5);
      wr('h10, 7);  wr('h11, 8);  wr('h15, 6);  wr('h16, 9);
      repeat (400) @(negedge clk);
      rd('h01, 5, "R10 readback");

      // R10: write on the frame-wrap edge applies one frame later
      wr_at_load('h01, 3);
      rd('h01, 3, "R10 readback at load");
      repeat (300) @(negedge clk);

      // R9: both polarities inverted
      wr('h18, 'hC0);
      repeat (300) @(negedge clk);

      // R8: lock the low registers
      wr('h11, 'h88);
      wr('h00, 'h55);
      rd('h00, 7, "R8 locked reg0");
      wr('h04, 'h01);
      rd('h04, 8, "R8 locked reg4");
      wr('h07, 'hFF);
      rd('h07, 'h10, "R8 ovfl bit4 only");
      repeat (200) @(negedge clk);
      wr('h11, 'h08);
      wr('h07, 'h00);
      rd('h07, 0, "R8 unlocked");

      // R12: indices past the bank
      wr('h1F, 'hA5);
      rd('h1F, 0, "R12 high index");
      rd('h19, 0, "R12 high index");

      // wide configuration with overflow and 6-bit blank end
      wr('h00, 40); wr('h01, 31); wr('h02, 32); wr('h03, 'h0C);
      wr('h04, 34); wr('h05, 'h85);
      wr('h06, 'h0A); wr('h07, 'hA2); wr('h12, 'hFF);
      wr('h10, 'h01); wr('h11, 'h04);
      wr('h15, 'h05); wr('h09, 'h20); wr('h16, 'h08);
      wr('h18, 'h40);
      repeat (52000) @(negedge clk);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule